// File: doc/BRIEF.md
# Cipher Command Queue Front-End

This block sits in front of a block-cipher accelerator and accepts a stream of 32-bit command words that software writes to a memory-mapped window. The words are queued in a FIFO. While the queue is running, the block takes one word at a time, decodes its 4-bit opcode, and acts on it. It loads key configurations into two key slots, hands crypt requests to an execute handshake, and raises interrupt flags when a barrier asks for one.

Status flags record malformed or unusable commands. These cover unknown opcodes, writes that arrive while the queue is full, key loads with reserved field values, and crypt requests that name a key slot that was never loaded. Each flag is cleared by writing a one to it. Each flag can be masked, and the unmasked flags are combined into one interrupt line.

A control register starts and stops the queue, flushes the FIFO, or resets the whole front-end. A read-only status register reports the FIFO pointers, fill level, full flag and empty flag. The cipher datapath is outside this block: an accepted crypt command only appears on the execute outputs until the consumer acknowledges it.

Top module: `cmdq_front`

## Requirements
- R1: After reset the FIFO is empty with both pointers at 0, all status flags and enables are 0, the queue is stopped, and irq and exec_valid are low.
- R2: A write to offset 0x200 while the FIFO is not full appends the word. The FIFO status register at offset 0x24 reads as follows: write pointer in bits 31:24, read pointer in bits 23:16, fill level in bits 15:8, full in bit 2, empty in bit 1, and zero in all other bits.
- R3: A write to offset 0x200 while the FIFO is full discards the word and sets status bit 1.
- R4: The control register is at offset 0x08. Writing bit 0 starts the queue and writing bit 1 stops it; if both are written, stop wins. Reading the control register returns the running state in bit 0. Words leave the FIFO only while the queue is running.
- R5: A dequeued word whose opcode (bits 31:28) is 0 or greater than 8 sets status bit 2.
- R6: Opcode 1 loads a key slot. Bit 27 selects the slot, bits 26:24 the key source (0 to 3), bits 23:22 the key length (0, 1 or 2), bit 20 the direction, and bits 17:16 the chaining mode (0, 1 or 2). The stored values of a slot appear on the exec_key_* outputs and on exec_encrypt and exec_mode whenever a crypt request for that slot is presented.
- R7: A key load with key source 4 to 7, key length 3 or mode 3 leaves the named slot unloaded. It sets status bit 7 for slot 0 or status bit 13 for slot 1.
- R8: Opcode 5 is a crypt request. Bit 27 selects the key slot, bits 26:25 the IV slot and bits 24:0 the length. If the key slot is loaded, exec_valid rises on the clock edge that dequeues the word. The request fields then stay constant until exec_ready is sampled high, and no other word is dequeued while the request is pending.
- R9: A crypt request that names an unloaded key slot is dropped without raising exec_valid. It sets status bit 11 for slot 0 or status bit 17 for slot 1.
- R10: Opcode 8 with bit 27 set sets status bit 5. With bit 27 clear it has no effect.
- R11: The status register is at offset 0x18 and is cleared by writing ones; a flag being set in the same cycle wins over its clear. The enable register at offset 0x1C can be read and written. irq is the OR of all status bits ANDed with their enable bits.
- R12: Control bit 2 empties the FIFO and returns both pointers to 0. Control bit 3 does the same, and also stops the queue, unloads both key slots, clears all status flags and drops any pending crypt request.
- R13: Opcodes 2, 3, 4, 6 and 7 are dequeued with no effect on status, key slots or execute outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 12 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| irq | output | 1 | Masked interrupt request |
| exec_valid | output | 1 | Crypt request pending |
| exec_ready | input | 1 | Consumer accepts the pending request |
| exec_key_slot | output | 1 | Key slot of the request |
| exec_iv_slot | output | 2 | IV slot of the request |
| exec_len | output | 25 | Length of the request |
| exec_key_sel | output | 3 | Key source stored in the selected slot |
| exec_key_len | output | 2 | Key length code stored in the selected slot |
| exec_encrypt | output | 1 | Direction stored in the selected slot |
| exec_mode | output | 2 | Chaining mode stored in the selected slot |

## Verification
Every register write takes effect on the clock edge that samples it. A word written to the window can be dequeued at the next edge at the earliest, provided the queue is running, and its status flag or exec_valid appears on that same edge. A cleared flag reads as zero one edge after the clearing write. rd_data follows rd_addr combinationally from the registered state. The bench steps a behavioural reference model once per rising edge, using the same inputs the design sampled. It compares irq, exec_valid, the request fields and the selected read register at the following falling edge. Directed register reads are made only after enough idle cycles for the queue to drain, so their expected values do not depend on exact pop timing.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

   // register offsets (bytes)
   localparam logic [11:0] OFS_CTRL  = 12'h008;
   localparam logic [11:0] OFS_STAT  = 12'h018;
   localparam logic [11:0] OFS_MASK  = 12'h01C;
   localparam logic [11:0] OFS_FSTAT = 12'h024;
   localparam logic [11:0] OFS_WIN   = 12'h200;

   // control bits
   localparam int CB_GO    = 0;
   localparam int CB_HALT  = 1;
   localparam int CB_FLUSH = 2;
   localparam int CB_RESET = 3;

   // status bit positions
   localparam int SB_OVF  = 1;
   localparam int SB_UNK  = 2;
   localparam int SB_FLAG = 5;

   // opcodes
   localparam logic [3:0] OPC_KEY   = 4'd1;
   localparam logic [3:0] OPC_RUN   = 4'd5;
   localparam logic [3:0] OPC_FENCE = 4'd8;

   localparam int CMD_W   = 32;
   localparam int LEN_W   = 25;
   localparam int NSLOT   = 2;
   localparam int STAT_W  = 32;

   typedef struct packed {
      logic [2:0] src;
      logic [1:0] klen;
      logic       enc;
      logic [1:0] mode;
   } keycfg_t;

   function automatic int bad_key_pos(int s);
      return (s == 0) ? 7 : 13;
   endfunction

   function automatic int no_key_pos(int s);
      return (s == 0) ? 11 : 17;
   endfunction

endpackage

// File: rtl/cmdq_fifo.sv
module cmdq_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          flush,
   input  logic                          push,
   input  logic                          pop,
   input  logic [WIDTH-1:0]              din,
   output logic [WIDTH-1:0]              dout,
   output logic [$clog2(DEPTH)-1:0]      wptr,
   output logic [$clog2(DEPTH)-1:0]      rptr,
   output logic [$clog2(DEPTH):0]        level,
   output logic                          full,
   output logic                          empty
);
   localparam int PW = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || DEPTH > 128 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("cmdq_fifo: DEPTH must be a power of two in 2..128");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("cmdq_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic do_push, do_pop;

   assign full    = level == (PW+1)'(DEPTH);
   assign empty   = level == '0;
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         level <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         level <= level + (PW+1)'(do_push) - (PW+1)'(do_pop);
      end
   end

   // R2
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= (PW+1)'(DEPTH));

   // R2
   push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !flush) |=> level == $past(level) + 1'b1);

endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
   import cmdq_pkg::*;
(
   input  logic [CMD_W-1:0] word,
   output logic             unknown,
   output logic             fence_irq,
   output logic             key_wr,
   output logic             key_ok,
   output logic             key_slot,
   output keycfg_t          key_cfg,
   output logic             run,
   output logic             run_slot,
   output logic [1:0]       run_iv,
   output logic [LEN_W-1:0] run_len
);
   logic [3:0] op;

   assign op        = word[31:28];
   assign unknown   = (op == 4'd0) || (op > OPC_FENCE);
   assign fence_irq = (op == OPC_FENCE) && word[27];

   assign key_wr           = op == OPC_KEY;
   assign key_slot         = word[27];
   assign key_cfg.src      = word[26:24];
   assign key_cfg.klen     = word[23:22];
   assign key_cfg.enc      = word[20];
   assign key_cfg.mode     = word[17:16];
   assign key_ok           = (word[26:24] <= 3'd3) && (word[23:22] != 2'd3)
                             && (word[17:16] != 2'd3);

   assign run      = op == OPC_RUN;
   assign run_slot = word[27];
   assign run_iv   = word[26:25];
   assign run_len  = word[LEN_W-1:0];

   // word[21], word[19:18] and word[15:0] are ignored by key loads
endmodule

// File: rtl/cmdq_irq.sv
module cmdq_irq #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_all,
   input  logic [W-1:0] set_vec,
   input  logic         w1c_we,
   input  logic [W-1:0] w1c_mask,
   input  logic         en_we,
   input  logic [W-1:0] en_data,
   output logic [W-1:0] stat,
   output logic [W-1:0] en,
   output logic         irq
);
   generate
      if (W < 18) begin : g_bad_w
         $error("cmdq_irq: W must cover bit 17");
      end
   endgenerate

   logic [W-1:0] clr;
   assign clr = w1c_we ? w1c_mask : '0;
   assign irq = |(stat & en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
         en   <= '0;
      end else begin
         stat <= clr_all ? '0 : ((stat & ~clr) | set_vec);
         if (en_we) en <= en_data;
      end
   end

   // R11
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_vec && !clr_all) |=> ((stat & $past(set_vec)) == $past(set_vec)));

   // R12
   reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> stat == '0);

endmodule

// File: rtl/cmdq_front.sv
module cmdq_front
   import cmdq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [31:0]       rd_data,
   output logic              irq,
   output logic              exec_valid,
   input  logic              exec_ready,
   output logic              exec_key_slot,
   output logic [1:0]        exec_iv_slot,
   output logic [LEN_W-1:0]  exec_len,
   output logic [2:0]        exec_key_sel,
   output logic [1:0]        exec_key_len,
   output logic              exec_encrypt,
   output logic [1:0]        exec_mode
);
   localparam int PW = $clog2(DEPTH);

   generate
      if (AW < 10) begin : g_bad_aw
         $error("cmdq_front: AW must reach the window offset");
      end
   endgenerate

   // bus decode
   logic win_we, ctrl_we, stat_we, mask_we;
   assign win_we  = wr_en && (wr_addr == AW'(OFS_WIN));
   assign ctrl_we = wr_en && (wr_addr == AW'(OFS_CTRL));
   assign stat_we = wr_en && (wr_addr == AW'(OFS_STAT));
   assign mask_we = wr_en && (wr_addr == AW'(OFS_MASK));

   logic ctrl_rst, flush;
   assign ctrl_rst = ctrl_we && wr_data[CB_RESET];
   assign flush    = ctrl_we && (wr_data[CB_FLUSH] || wr_data[CB_RESET]);

   // run state
   logic running_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    running_q <= 1'b0;
      else if (ctrl_we && (wr_data[CB_HALT] || wr_data[CB_RESET])) running_q <= 1'b0;
      else if (ctrl_we && wr_data[CB_GO])            running_q <= 1'b1;
   end

   // queue
   logic [CMD_W-1:0] head;
   logic [PW-1:0]    f_wptr, f_rptr;
   logic [PW:0]      f_level;
   logic             f_full, f_empty, pop;

   assign pop = running_q && !f_empty && !exec_valid && !flush;

   cmdq_fifo #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (win_we),
      .pop   (pop),
      .din   (wr_data),
      .dout  (head),
      .wptr  (f_wptr),
      .rptr  (f_rptr),
      .level (f_level),
      .full  (f_full),
      .empty (f_empty)
   );

   // decode
   logic             d_unknown, d_fence, d_key_wr, d_key_ok, d_key_slot;
   logic             d_run, d_run_slot;
   logic [1:0]       d_run_iv;
   logic [LEN_W-1:0] d_run_len;
   keycfg_t          d_key_cfg;

   cmdq_decode u_dec (
      .word      (head),
      .unknown   (d_unknown),
      .fence_irq (d_fence),
      .key_wr    (d_key_wr),
      .key_ok    (d_key_ok),
      .key_slot  (d_key_slot),
      .key_cfg   (d_key_cfg),
      .run       (d_run),
      .run_slot  (d_run_slot),
      .run_iv    (d_run_iv),
      .run_len   (d_run_len)
   );

   // key slots
   logic    loaded_q [NSLOT];
   keycfg_t cfg_q    [NSLOT];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            loaded_q[g] <= 1'b0;
            cfg_q[g]    <= '0;
         end else if (ctrl_rst) begin
            loaded_q[g] <= 1'b0;
         end else if (pop && d_key_wr && d_key_slot == 1'(g)) begin
            loaded_q[g] <= d_key_ok;
            if (d_key_ok) cfg_q[g] <= d_key_cfg;
         end
      end
   end

   logic go;
   assign go = pop && d_run && loaded_q[d_run_slot];

   // status flags
   logic [STAT_W-1:0] set_vec, stat, en;
   always_comb begin
      set_vec          = '0;
      set_vec[SB_OVF]  = win_we && f_full;
      set_vec[SB_UNK]  = pop && d_unknown;
      set_vec[SB_FLAG] = pop && d_fence;
      for (int s = 0; s < NSLOT; s++) begin
         if (pop && d_key_wr && !d_key_ok && d_key_slot == 1'(s))
            set_vec[bad_key_pos(s)] = 1'b1;
         if (pop && d_run && !loaded_q[d_run_slot] && d_run_slot == 1'(s))
            set_vec[no_key_pos(s)] = 1'b1;
      end
   end

   cmdq_irq #(.W(STAT_W)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_all  (ctrl_rst),
      .set_vec  (set_vec),
      .w1c_we   (stat_we),
      .w1c_mask (wr_data),
      .en_we    (mask_we),
      .en_data  (wr_data),
      .stat     (stat),
      .en       (en),
      .irq      (irq)
   );

   // execute handshake
   logic             ex_slot_q;
   logic [1:0]       ex_iv_q;
   logic [LEN_W-1:0] ex_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exec_valid <= 1'b0;
         ex_slot_q  <= 1'b0;
         ex_iv_q    <= '0;
         ex_len_q   <= '0;
      end else if (ctrl_rst) begin
         exec_valid <= 1'b0;
      end else if (exec_valid && exec_ready) begin
         exec_valid <= 1'b0;
      end else if (go) begin
         exec_valid <= 1'b1;
         ex_slot_q  <= d_run_slot;
         ex_iv_q    <= d_run_iv;
         ex_len_q   <= d_run_len;
      end
   end

   keycfg_t ex_cfg;
   assign ex_cfg        = cfg_q[ex_slot_q];
   assign exec_key_slot = ex_slot_q;
   assign exec_iv_slot  = ex_iv_q;
   assign exec_len      = ex_len_q;
   assign exec_key_sel  = ex_cfg.src;
   assign exec_key_len  = ex_cfg.klen;
   assign exec_encrypt  = ex_cfg.enc;
   assign exec_mode     = ex_cfg.mode;

   // read mux
   always_comb begin
      rd_data = '0;
      if (rd_addr == AW'(OFS_CTRL))       rd_data = {31'd0, running_q};
      else if (rd_addr == AW'(OFS_STAT))  rd_data = stat;
      else if (rd_addr == AW'(OFS_MASK))  rd_data = en;
      else if (rd_addr == AW'(OFS_FSTAT))
         rd_data = {8'(f_wptr), 8'(f_rptr), 8'(f_level), 5'd0, f_full, f_empty, 1'b0};
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_we && f_full) |=> stat[SB_OVF]);

   // R5
   unknown_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && d_unknown) |=> stat[SB_UNK]);

   // R8
   exec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && !exec_ready && !ctrl_rst) |=> (exec_valid && $stable(exec_len)
                                                    && $stable(exec_iv_slot)));

   // R4
   stopped_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running_q && !flush) |=> f_rptr == $past(f_rptr));

   // R8
   no_pop_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && !flush) |=> f_rptr == $past(f_rptr));

endmodule

// File: tb/sim_cmdq_front.sv
`timescale 1ns/100ps
module sim_cmdq_front;
   localparam int DEPTH = 16;
   localparam logic [11:0] A_CTRL = 12'h008, A_ST = 12'h018, A_EN = 12'h01C,
                           A_FS = 12'h024, A_WIN = 12'h200;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, wr_en, exec_ready;
   logic [11:0] wr_addr, rd_addr;
   logic [31:0] wr_data, rd_data;
   logic        irq, exec_valid, exec_key_slot, exec_encrypt;
   logic [1:0]  exec_iv_slot, exec_key_len, exec_mode;
   logic [2:0]  exec_key_sel;
   logic [24:0] exec_len;

   cmdq_front #(.DEPTH(DEPTH), .AW(12)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .exec_valid(exec_valid),
      .exec_ready(exec_ready), .exec_key_slot(exec_key_slot), .exec_iv_slot(exec_iv_slot),
      .exec_len(exec_len), .exec_key_sel(exec_key_sel), .exec_key_len(exec_key_len),
      .exec_encrypt(exec_encrypt), .exec_mode(exec_mode));

   int nchk = 0, nfail = 0, cyc = 0;

   // reference model state
   logic [31:0] q[$];
   bit          m_run, m_ev, m_exs;
   logic [31:0] m_stat, m_en;
   bit          m_ld[2];
   logic [7:0]  m_cfg[2];
   logic [1:0]  m_exi;
   logic [24:0] m_exl;
   int          m_wp, m_rp;
   bit          rdy_g;
   logic [11:0] ra_g;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(logic [11:0] a);
      logic [31:0] v = 32'd0;
      if (a == A_CTRL)      v = {31'd0, m_run};
      else if (a == A_ST)   v = m_stat;
      else if (a == A_EN)   v = m_en;
      else if (a == A_FS)
         v = {8'(m_wp), 8'(m_rp), 8'(q.size()), 5'd0, q.size() == DEPTH, q.size() == 0, 1'b0};
      return v;
   endfunction

   task automatic model_step(bit we, logic [11:0] a, logic [31:0] d, bit rdy);
      bit full = (q.size() == DEPTH);
      bit fl   = we && a == A_CTRL && (d[2] || d[3]);
      bit rs   = we && a == A_CTRL && d[3];
      bit popn = m_run && q.size() != 0 && !m_ev && !fl;
      logic [31:0] setv = 32'd0, clr = 32'd0, h;
      if (we && a == A_WIN && full) setv[1] = 1'b1;
      if (m_ev && rdy) m_ev = 1'b0;
      if (popn) begin
         h = q.pop_front();
         m_rp = (m_rp + 1) % DEPTH;
         case (h[31:28])
            4'd1: if (h[26:24] <= 3 && h[23:22] != 3 && h[17:16] != 3) begin
                     m_ld[h[27]]  = 1'b1;
                     m_cfg[h[27]] = {h[26:24], h[23:22], h[20], h[17:16]};
                  end else begin
                     m_ld[h[27]] = 1'b0;
                     setv[h[27] ? 13 : 7] = 1'b1;
                  end
            4'd5: if (m_ld[h[27]]) begin
                     m_ev = 1'b1; m_exs = h[27]; m_exi = h[26:25]; m_exl = h[24:0];
                  end else setv[h[27] ? 17 : 11] = 1'b1;
            4'd8: if (h[27]) setv[5] = 1'b1;
            4'd2, 4'd3, 4'd4, 4'd6, 4'd7: ;
            default: setv[2] = 1'b1;
         endcase
      end
      if (we && a == A_WIN && !full && !fl) begin
         q.push_back(d);
         m_wp = (m_wp + 1) % DEPTH;
      end
      if (we && a == A_ST) clr = d;
      if (we && a == A_EN) m_en = d;
      m_stat = (m_stat & ~clr) | setv;
      if (we && a == A_CTRL) begin
         if (d[1] || d[3]) m_run = 1'b0;
         else if (d[0]) m_run = 1'b1;
      end
      if (fl) begin q.delete(); m_wp = 0; m_rp = 0; end
      if (rs) begin m_stat = 0; m_ld[0] = 0; m_ld[1] = 0; m_ev = 0; end
   endtask

   task automatic compare();
      check("R11 irq", {31'd0, irq}, {31'd0, |(m_stat & m_en)});
      check("R8 exec_valid", {31'd0, exec_valid}, {31'd0, m_ev});
      if (m_ev) begin
         check("R8 request fields", {4'd0, exec_key_slot, exec_iv_slot, exec_len},
               {4'd0, m_exs, m_exi, m_exl});
         check("R6 key fields", {24'd0, exec_key_sel, exec_key_len, exec_encrypt, exec_mode},
               {24'd0, m_cfg[m_exs]});
      end
      check("R2 register read", rd_data, m_read(rd_addr));
   endtask

   task automatic step(bit we, logic [11:0] a, logic [31:0] d, logic [11:0] ra);
      wr_en = we; wr_addr = a; wr_data = d; exec_ready = rdy_g; rd_addr = ra;
      @(posedge clk);
      model_step(we, a, d, rdy_g);
      @(negedge clk);
      compare();
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      step(1'b1, a, d, ra_g);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(1'b0, 12'd0, 32'd0, ra_g);
   endtask

   task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] mask, logic [31:0] exp);
      step(1'b0, 12'd0, 32'd0, a);
      check(tag, rd_data & mask, exp);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired R1 actual=%0d expected<20000", cyc);
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; exec_ready = 1'b0;
      m_run = 0; m_ev = 0; m_exs = 0; m_stat = 0; m_en = 0; m_ld[0] = 0; m_ld[1] = 0;
      m_cfg[0] = 0; m_cfg[1] = 0; m_exi = 0; m_exl = 0; m_wp = 0; m_rp = 0;
      rdy_g = 1'b1; ra_g = A_FS;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk("R1 fifo status", A_FS, 32'hFFFF_FFFF, 32'h0000_0002);
      rd_chk("R1 status", A_ST, 32'hFFFF_FFFF, 32'd0);
      rd_chk("R1 control", A_CTRL, 32'hFFFF_FFFF, 32'd0);
      check("R1 irq", {31'd0, irq}, 32'd0);
      check("R1 exec_valid", {31'd0, exec_valid}, 32'd0);

      wr(A_EN, 32'hFFFF_FFFF);
      // R2 queued while stopped
      wr(A_WIN, 32'h1091_0000);   // key slot0: src0, len256, encrypt, CBC
      wr(A_WIN, 32'h5400_0064);   // crypt slot0, iv 2, len 100
      wr(A_WIN, 32'h8800_0000);   // barrier with flag
      rd_chk("R2 pointers and level", A_FS, 32'hFFFF_FFFF, 32'h0300_0300);

      // R8 request held while not accepted
      rdy_g = 1'b0;
      wr(A_CTRL, 32'h1);
      idle(6);
      check("R8 pending", {31'd0, exec_valid}, 32'd1);
      check("R8 length", {7'd0, exec_len}, 32'd100);
      check("R6 key length/mode/dir", {27'd0, exec_key_len, exec_encrypt, exec_mode}, 32'h15);
      rd_chk("R8 no pop while pending", A_FS, 32'h0000_FF00, 32'h0000_0100);
      rdy_g = 1'b1;
      idle(4);
      rd_chk("R10 flag bit", A_ST, 32'h0000_0020, 32'h0000_0020);
      check("R11 irq raised", {31'd0, irq}, 32'd1);
      wr(A_ST, 32'hFFFF_FFFF);
      rd_chk("R11 write-one clear", A_ST, 32'hFFFF_FFFF, 32'd0);

      // R9 empty slot
      wr(A_WIN, 32'h5800_0010);
      idle(3);
      rd_chk("R9 slot1 empty", A_ST, 32'hFFFF_FFFF, 32'h0002_0000);
      check("R9 not executed", {31'd0, exec_valid}, 32'd0);
      wr(A_ST, 32'hFFFF_FFFF);

      // R5 unknown opcodes
      wr(A_WIN, 32'h0000_0000);
      wr(A_WIN, 32'h9000_0000);
      idle(3);
      rd_chk("R5 unknown", A_ST, 32'hFFFF_FFFF, 32'h0000_0004);
      wr(A_EN, 32'd0);
      check("R11 masked", {31'd0, irq}, 32'd0);
      wr(A_EN, 32'hFFFF_FFFF);
      check("R11 unmasked", {31'd0, irq}, 32'd1);
      wr(A_ST, 32'hFFFF_FFFF);

      // R7 invalid key loads
      wr(A_WIN, 32'h1803_0000);
      idle(3);
      rd_chk("R7 slot1 invalid", A_ST, 32'hFFFF_FFFF, 32'h0000_2000);
      wr(A_ST, 32'hFFFF_FFFF);
      wr(A_WIN, 32'h1500_0000);
      wr(A_WIN, 32'h5000_0008);
      idle(4);
      rd_chk("R7 slot0 invalid then empty", A_ST, 32'hFFFF_FFFF, 32'h0000_0880);
      wr(A_ST, 32'hFFFF_FFFF);

      // R13 ignored opcodes, R10 barrier without flag
      wr(A_WIN, 32'h2000_0000);
      wr(A_WIN, 32'h3000_0000);
      wr(A_WIN, 32'h4000_0000);
      wr(A_WIN, 32'h6000_0000);
      wr(A_WIN, 32'h7000_0000);
      wr(A_WIN, 32'h8000_0000);
      idle(8);
      rd_chk("R13 no status", A_ST, 32'hFFFF_FFFF, 32'd0);
      rd_chk("R13 drained", A_FS, 32'h0000_FF02, 32'h0000_0002);
      check("R13 no execute", {31'd0, exec_valid}, 32'd0);

      // slot1 valid load then crypt
      wr(A_WIN, 32'h1800_0000);
      wr(A_WIN, 32'h5A00_0005);
      idle(4);

      // R4 start+stop -> stopped; R3 overflow
      wr(A_CTRL, 32'h3);
      rd_chk("R4 stop wins", A_CTRL, 32'hFFFF_FFFF, 32'd0);
      for (int i = 0; i < DEPTH + 1; i++) wr(A_WIN, 32'h8800_0000);
      idle(3);
      rd_chk("R3 R4 full and held", A_FS, 32'h0000_FF06, 32'h0000_1004);
      rd_chk("R3 overflow bit", A_ST, 32'h0000_0002, 32'h0000_0002);
      wr(A_ST, 32'hFFFF_FFFF);

      // R12 flush and reset
      wr(A_CTRL, 32'h4);
      rd_chk("R12 flushed", A_FS, 32'hFFFF_FFFF, 32'h0000_0002);
      wr(A_CTRL, 32'h1);
      wr(A_WIN, 32'h1091_0000);
      idle(3);
      wr(A_WIN, 32'h0000_0000);
      idle(3);
      wr(A_CTRL, 32'h8);
      rd_chk("R12 stopped", A_CTRL, 32'hFFFF_FFFF, 32'd0);
      rd_chk("R12 status cleared", A_ST, 32'hFFFF_FFFF, 32'd0);
      wr(A_CTRL, 32'h1);
      wr(A_WIN, 32'h5000_0001);
      idle(3);
      rd_chk("R12 slots unloaded", A_ST, 32'hFFFF_FFFF, 32'h0000_0800);

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule